// File: doc/BRIEF.md
# Bit-Sliced Four-Function Arithmetic/Logic Unit

This block combines two 32-bit operands under a 3-bit operation code. It returns a 32-bit result, the carry out of the most significant position and a flag for an undefined code. The datapath is a row of identical one-bit slices linked by a ripple carry. Each slice receives one bit of each operand, the incoming carry and all three code bits. It can complement its B bit and forms AND, OR and a full-adder sum. A four-way selector picks the slice output.

The highest code bit has two jobs. It complements operand B in every slice, and it is also the carry into slice 0. ADD and SUB therefore share the same adder chain: SUB forms A plus the inverse of B plus one. An output register can be turned on by a parameter to ease timing, and it is on by default. With the register on, every result is due one clock after its operands and code are captured.

Top module: `alu4f_top`

## Requirements
- R1: Code 3'b000 gives result = A AND B, bit by bit, with carry_out = 0 and illegal_op = 0.
- R2: Code 3'b001 gives result = A OR B, bit by bit, with carry_out = 0 and illegal_op = 0.
- R3: Code 3'b010 gives result = (A + B) mod 2^32, with carry_out equal to bit 32 of the unsigned 33-bit sum and illegal_op = 0.
- R4: Code 3'b110 gives result = (A + ~B + 1) mod 2^32, with carry_out equal to bit 32 of that 33-bit sum and illegal_op = 0. carry_out is 1 exactly when A >= B as unsigned numbers.
- R5: For the logic codes 3'b000 and 3'b001, carry_out is forced to 0 whatever the carry chain produces.
- R6: Codes 3'b011, 3'b100, 3'b101 and 3'b111 give result = 0, carry_out = 0 and illegal_op = 1.
- R7: With REG_OUT = 1, the outputs show the function of the operands and code captured at the previous rising clock edge.
- R8: While the synchronous active-high reset is sampled high at a rising edge, result, carry_out and illegal_op become 0 at that edge, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 32 | Operand A |
| op_b | input | 32 | Operand B |
| opcode | input | 3 | Operation code |
| result | output | 32 | Selected result |
| carry_out | output | 1 | Carry out of the top slice (0 for logic and undefined codes) |
| illegal_op | output | 1 | High for an undefined operation code |

## Verification
The result, carry and undefined-code flag all come out of the output register. Each of them is due at the first rising edge after the operands and code are applied, and a reset sampled at an edge clears them at that same edge. The bench changes inputs only on falling edges. It compares the outputs on the next falling edge against expectations computed from the inputs applied one falling edge earlier, so every comparison falls exactly one register stage after its stimulus.

// File: rtl/alu4f_pkg.sv
package alu4f_pkg;

    localparam int unsigned OPC_W = 3;

    typedef enum logic [OPC_W-1:0] {
        OPC_AND = 3'b000,
        OPC_OR  = 3'b001,
        OPC_ADD = 3'b010,
        OPC_SUB = 3'b110
    } alu_opc_e;

    typedef struct packed {
        logic legal;
        logic arith;
    } op_ctrl_t;

    typedef struct packed {
        logic res;
        logic cout;
    } slice_out_t;

    function automatic logic opc_is_legal(input logic [OPC_W-1:0] code);
        case (code)
            OPC_AND, OPC_OR, OPC_ADD, OPC_SUB: return 1'b1;
            default:                           return 1'b0;
        endcase
    endfunction

    function automatic logic maj3(input logic x, input logic y, input logic z);
        return (x & y) | (x & z) | (y & z);
    endfunction

endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
    import alu4f_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output op_ctrl_t         ctrl
);
    always_comb begin
        ctrl.legal = opc_is_legal(opcode);
        ctrl.arith = ctrl.legal & opcode[1];
    end
endmodule

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
    import alu4f_pkg::*;
(
    input  logic             a,
    input  logic             b,
    input  logic             cin,
    input  logic [OPC_W-1:0] op,
    output slice_out_t       q
);
    logic b_eff;
    logic and_v;
    logic or_v;
    logic sum_v;

    // 2:1 selector: true or complemented B
    assign b_eff = op[OPC_W-1] ? ~b : b;
    assign and_v = a & b_eff;
    assign or_v  = a | b_eff;
    assign sum_v = a ^ b_eff ^ cin;

    always_comb begin
        q.cout = maj3(a, b_eff, cin);
        case (op[1:0])
            2'b00:   q.res = and_v;
            2'b01:   q.res = or_v;
            2'b10:   q.res = sum_v;
            default: q.res = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu_slice_chain.sv
module alu_slice_chain
    import alu4f_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [OPC_W-1:0] op,
    output logic [WIDTH-1:0] res,
    output logic             cout
);
    logic [WIDTH:0] carry;

    // top code bit doubles as the carry into slice 0
    assign carry[0] = op[OPC_W-1];

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        slice_out_t so;
        alu_bit_slice u_slice (
            .a   (a[i]),
            .b   (b[i]),
            .cin (carry[i]),
            .op  (op),
            .q   (so)
        );
        assign res[i]     = so.res;
        assign carry[i+1] = so.cout;
    end

    assign cout = carry[WIDTH];
endmodule

// File: rtl/alu_out_stage.sv
module alu_out_stage #(
    parameter int unsigned WIDTH   = 32,
    parameter bit          REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] res_d,
    input  logic             cout_d,
    input  logic             ill_d,
    output logic [WIDTH-1:0] res_q,
    output logic             cout_q,
    output logic             ill_q
);
    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                res_q  <= '0;
                cout_q <= 1'b0;
                ill_q  <= 1'b0;
            end else begin
                res_q  <= res_d;
                cout_q <= cout_d;
                ill_q  <= ill_d;
            end
        end
    end else begin : g_comb
        logic unused_ok;
        assign unused_ok = clk ^ rst;
        assign res_q  = res_d;
        assign cout_q = cout_d;
        assign ill_q  = ill_d;
    end
endmodule

// File: rtl/alu4f_top.sv
module alu4f_top
    import alu4f_pkg::*;
#(
    parameter int unsigned WIDTH   = 32,
    parameter bit          REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [31:0]      op_a,
    input  logic [31:0]      op_b,
    input  logic [2:0]       opcode,
    output logic [31:0]      result,
    output logic             carry_out,
    output logic             illegal_op
);
    localparam int unsigned SUM_W = WIDTH + 1;

    op_ctrl_t         ctrl;
    logic [WIDTH-1:0] chain_res;
    logic             chain_cout;
    logic [WIDTH-1:0] res_next;
    logic             cout_next;
    logic             ill_next;

    alu_op_decode u_dec (
        .opcode (opcode),
        .ctrl   (ctrl)
    );

    alu_slice_chain #(.WIDTH(WIDTH)) u_chain (
        .a    (op_a),
        .b    (op_b),
        .op   (opcode),
        .res  (chain_res),
        .cout (chain_cout)
    );

    assign res_next  = ctrl.legal ? chain_res : '0;
    assign cout_next = ctrl.arith & chain_cout;
    assign ill_next  = ~ctrl.legal;

    alu_out_stage #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_out (
        .clk    (clk),
        .rst    (rst),
        .res_d  (res_next),
        .cout_d (cout_next),
        .ill_d  (ill_next),
        .res_q  (result),
        .cout_q (carry_out),
        .ill_q  (illegal_op)
    );

    // R1
    and_bitwise_chk: assert property (@(posedge clk) disable iff (rst)
        opcode == OPC_AND |-> chain_res == (op_a & op_b));

    // R3
    add_chain_chk: assert property (@(posedge clk) disable iff (rst)
        opcode == OPC_ADD |->
        {chain_cout, chain_res} == ({1'b0, op_a} + {1'b0, op_b}));

    // R4
    sub_chain_chk: assert property (@(posedge clk) disable iff (rst)
        opcode == OPC_SUB |->
        {chain_cout, chain_res} == ({1'b0, op_a} + {1'b0, ~op_b} + SUM_W'(1)));

    if (REG_OUT) begin : g_reg_chk
        logic armed;
        always_ff @(posedge clk) begin
            if (rst) armed <= 1'b0;
            else     armed <= 1'b1;
        end

        // R5
        logic_cout_zero_chk: assert property (@(posedge clk) disable iff (rst)
            armed && ($past(opcode) == OPC_AND || $past(opcode) == OPC_OR)
            |-> !carry_out);

        // R6
        illegal_zero_chk: assert property (@(posedge clk) disable iff (rst)
            armed && !opc_is_legal($past(opcode))
            |-> result == '0 && !carry_out && illegal_op);

        // R8
        reset_clear_chk: assert property (@(posedge clk)
            $past(rst) && armed == 1'b0 && $past(armed) == 1'b1
            |-> result == '0 && !carry_out && !illegal_op);
    end
endmodule

// File: tb/test_alu4f_top.sv
module test_alu4f_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [2:0]  opcode = '0;
    logic [31:0] result;
    logic        carry_out;
    logic        illegal_op;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [31:0] exp_res  = '0;
    logic        exp_c    = 1'b0;
    logic        exp_ill  = 1'b0;
    string       exp_tag  = "R8";

    always #10 clk = ~clk;

    alu4f_top i_alu4f_top (
        .clk        (clk),
        .rst        (rst),
        .op_a       (op_a),
        .op_b       (op_b),
        .opcode     (opcode),
        .result     (result),
        .carry_out  (carry_out),
        .illegal_op (illegal_op)
    );

    // behavioural reference, computed from the requirements
    task automatic model(input logic [31:0] a, input logic [31:0] b, input logic [2:0] op);
        longint unsigned s;
        case (op)
            3'b000: begin exp_res = a & b; exp_c = 0; exp_ill = 0; exp_tag = "R1/R5"; end
            3'b001: begin exp_res = a | b; exp_c = 0; exp_ill = 0; exp_tag = "R2/R5"; end
            3'b010: begin
                s = longint'(a) + longint'(b);
                exp_res = s[31:0]; exp_c = s[32]; exp_ill = 0; exp_tag = "R3";
            end
            3'b110: begin
                s = longint'(a) - longint'(b);
                exp_res = s[31:0]; exp_c = (a >= b); exp_ill = 0; exp_tag = "R4";
            end
            default: begin exp_res = '0; exp_c = 0; exp_ill = 1; exp_tag = "R6"; end
        endcase
    endtask

    task automatic compare();
        n_tests++;
        if (result !== exp_res || carry_out !== exp_c || illegal_op !== exp_ill) begin
            n_fail++;
            $display("FAIL %s (R7 timing): got res=%h c=%b ill=%b exp res=%h c=%b ill=%b",
                     exp_tag, result, carry_out, illegal_op, exp_res, exp_c, exp_ill);
        end
    endtask

    task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic [2:0] op);
        @(negedge clk);
        compare();
        rst    = 1'b0;
        op_a   = a;
        op_b   = b;
        opcode = op;
        model(a, b, op);
    endtask

    task automatic apply_rst(input logic [31:0] a, input logic [31:0] b, input logic [2:0] op);
        @(negedge clk);
        compare();
        rst    = 1'b1;
        op_a   = a;
        op_b   = b;
        opcode = op;
        exp_res = '0; exp_c = 0; exp_ill = 0; exp_tag = "R8";
    endtask

    initial begin
        // R8: reset with live inputs
        apply_rst(32'hFFFF_FFFF, 32'h1, 3'b010);
        apply_rst(32'h1234_5678, 32'h0, 3'b100);
        // R1 / R2 patterns
        apply(32'hF0F0_F0F0, 32'hFF00_FF00, 3'b000);
        apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b000);
        apply(32'hF0F0_F0F0, 32'h0F0F_0F0F, 3'b001);
        apply(32'h0, 32'h0, 3'b001);
        // R3 carry boundaries
        apply(32'hFFFF_FFFF, 32'h1, 3'b010);
        apply(32'h7FFF_FFFF, 32'h1, 3'b010);
        apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b010);
        apply(32'h0, 32'h0, 3'b010);
        // R4 borrow boundaries
        apply(32'h5, 32'h5, 3'b110);
        apply(32'h0, 32'h1, 3'b110);
        apply(32'h8000_0000, 32'h7FFF_FFFF, 3'b110);
        apply(32'h0, 32'h0, 3'b110);
        // R5: operands that would carry, under logic codes
        apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b001);
        apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b000);
        // R6: every undefined code
        apply(32'hFFFF_FFFF, 32'h0, 3'b011);
        apply(32'hFFFF_FFFF, 32'h0, 3'b100);
        apply(32'hFFFF_FFFF, 32'h0, 3'b101);
        apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b111);
        // R8 mid-run, then R7 back-to-back mixed stream
        apply_rst(32'hA5A5_A5A5, 32'h5A5A_5A5A, 3'b001);
        for (int i = 0; i < 600; i++) begin
            apply($urandom, $urandom, 3'($urandom % 8));
        end
        @(negedge clk);
        compare();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got hung run exp completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule